// File: doc/BRIEF.md
# Reloadable Event Down-Counter

This block is a down-counter that is driven by events rather than by the clock. An event is either a chosen edge of an asynchronous external pin or a single-cycle pulse from a neighbouring timer. Each event decrements the count by one. When an event arrives with the count at zero, the counter takes the value held in the reload register and keeps running. It also drives a one-cycle underflow pulse, which serves as the interrupt request and can feed the cascade input of another instance. With reload value n, the block divides the event rate by n+1.

Software-style access is a plain register bus. A write strobe with 16-bit data loads the count/reload value, and a second strobe with 8-bit data loads the mode byte. The live count and the mode byte are always visible on output ports, and a level input starts and stops counting.

A value write behaves in one of two ways. While the counter is stopped, and after start until the first qualified event, the write loads both the counter and the reload register. Once that first event has been counted, a write only changes the reload register, and the counter picks up the new value at its next reload.

Top module: `evt_down_counter`

## Requirements
- R1: After reset, count_o is 0, mode_o is 0 and uflow_o is 0.
- R2: While run_i is 1 and the operating-mode field mode[1:0] equals 01, each qualified event decrements count_o by one; with any other mode[1:0] value, events leave count_o unchanged.
- R3: An event that arrives with the count at 0 loads the reload value into the counter and pulses uflow_o high for exactly one cycle, so reload value n yields one pulse per n+1 events (n = 0 gives a pulse on every event).
- R4: While run_i is 0, events leave count_o unchanged.
- R5: A value write while run_i is 0, or after run_i rises but before the first counted event, loads both the counter and the reload register, so count_o shows the written value on the next cycle.
- R6: A value write after the first counted event since run_i rose changes only the reload register; count_o keeps counting from its old value and takes the new value at the next underflow.
- R7: With the pin selected, the edge field mode[3:2] selects falling edges (00), rising edges (01), both edges (10) or no events (11).
- R8: With the source bit mode[4] at 1, each high cycle of cascade_i is one event; the pin and the edge field then have no effect.
- R9: The pin passes through a two-flop synchroniser and each pin edge yields exactly one event; a pin change applied before rising clock edge k changes count_o at edge k+2.
- R10: Bits [4:0] of the mode byte are writable and bits [7:5] read as 0.
- R11: count_o always presents the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 counts, 0 halts |
| val_we_i | input | 1 | Write strobe for the count/reload value |
| val_wdata_i | input | 16 | Count/reload write data |
| mode_we_i | input | 1 | Write strobe for the mode byte |
| mode_wdata_i | input | 8 | Mode byte write data |
| evt_pin_i | input | 1 | Asynchronous external event pin |
| cascade_i | input | 1 | Single-cycle event pulse from another timer |
| count_o | output | 16 | Live counter value |
| mode_o | output | 8 | Mode byte readback |
| uflow_o | output | 1 | One-cycle underflow pulse and interrupt request |

## Verification
The pin is driven with isolated falling edges, isolated rising edges and full pulses under each of the four edge codes. This shows whether an edge is matched to the wrong code, and whether both-edge mode counts two events per pulse. The cascade input is pulsed while the pin still toggles, which separates the two sources. Value writes are placed while stopped, between start and the first event, and after counting has begun, so the bench can tell a direct load from a reload-only update. Long sequences down through zero, with reload values 2 and 0, show the reload value and the divide ratio in the count of underflow pulses.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  localparam logic [1:0] OPM_EVENT = 2'b01;

  typedef struct packed {
    logic [2:0] rsvd;
    logic       src_casc;
    edge_sel_e  edge_sel;
    logic [1:0] opm;
  } mode_t;
endpackage

// File: rtl/evc_pin_sync.sv
module evc_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int DW = SYNC_STAGES + 1;

  logic [DW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[DW-2:0], pin_i};
  end

  // sh_q[DW-2] is the synchronised pin, sh_q[DW-1] its previous sample
  assign rise_o =  sh_q[DW-2] & ~sh_q[DW-1];
  assign fall_o = ~sh_q[DW-2] &  sh_q[DW-1];

  a_r9_one_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
  a_r9_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  a_r9_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/evc_evt_sel.sv
module evc_evt_sel
  import evc_pkg::*;
(
  input  mode_t mode_i,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  casc_i,
  output logic  evt_o
);
  logic pin_evt;

  always_comb begin
    unique case (mode_i.edge_sel)
      EDGE_FALL: pin_evt = fall_i;
      EDGE_RISE: pin_evt = rise_i;
      EDGE_BOTH: pin_evt = rise_i | fall_i;
      default:   pin_evt = 1'b0;
    endcase
  end

  assign evt_o = mode_i.src_casc ? casc_i : pin_evt;
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         en_i,
  input  logic         evt_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         uflow_o
);
  logic [W-1:0] cnt_q, rld_q;
  logic         seen_q, uf_q;
  logic         hit, direct;

  assign hit    = run_i & en_i & evt_i;
  // writes reach the counter until the first counted event after start
  assign direct = ~run_i | ~seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      seen_q <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      uf_q <= 1'b0;
      if (!run_i)   seen_q <= 1'b0;
      else if (hit) seen_q <= 1'b1;
      if (we_i) rld_q <= wdata_i;
      if (we_i && direct) begin
        cnt_q <= wdata_i;
      end else if (hit) begin
        if (cnt_q == '0) begin
          cnt_q <= rld_q;
          uf_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign uflow_o = uf_q;

  a_r2_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !we_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) && !uflow_o);
  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !(we_i && direct) && cnt_q == '0) |=> uflow_o && cnt_q == $past(rld_q));
  a_r4_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !we_i) |=> $stable(cnt_q) && !uflow_o);
  a_r5_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !run_i) |=> cnt_q == $past(wdata_i));
  a_r6_rld_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && run_i && seen_q && !hit) |=> $stable(cnt_q) && rld_q == $past(wdata_i));
endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter
  import evc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             val_we_i,
  input  logic [CNT_W-1:0] val_wdata_i,
  input  logic             mode_we_i,
  input  logic [7:0]       mode_wdata_i,
  input  logic             evt_pin_i,
  input  logic             cascade_i,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       mode_o,
  output logic             uflow_o
);
  mode_t mode_q;
  logic  rise, fall, evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_t'({3'b000, mode_wdata_i[4:0]});
  end

  assign mode_o = mode_q;

  evc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (evt_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  evc_evt_sel u_sel (
    .mode_i (mode_q),
    .rise_i (rise),
    .fall_i (fall),
    .casc_i (cascade_i),
    .evt_o  (evt)
  );

  evc_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .en_i    (mode_q.opm == OPM_EVENT),
    .evt_i   (evt),
    .we_i    (val_we_i),
    .wdata_i (val_wdata_i),
    .cnt_o   (count_o),
    .uflow_o (uflow_o)
  );

  a_r10_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[7:5] == 3'b000);
  a_r8_casc_pin_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.src_casc && !cascade_i && !val_we_i) |=> $stable(count_o));
endmodule

// File: tb/sim_evt_down_counter.sv
module sim_evt_down_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        val_we = 1'b0;
  logic [15:0] val_wdata = '0;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_wdata = '0;
  logic        pin = 1'b1;
  logic        casc = 1'b0;
  logic [15:0] count;
  logic [7:0]  mode;
  logic        uflow;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_down_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .val_we_i(val_we), .val_wdata_i(val_wdata),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
    .evt_pin_i(pin), .cascade_i(casc),
    .count_o(count), .mode_o(mode), .uflow_o(uflow)
  );

  typedef struct {
    int    kind;  // 0 count, 1 underflow tally, 2 mode
    string tag;
    int    val;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0, uf_n = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n && uflow) uf_n++;

  // monitor: pop expected items and compare with what the design shows
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = (it.kind == 0) ? int'(count) : (it.kind == 1) ? uf_n : int'(mode);
      n_chk++;
      if (act != it.val) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.tag, it.kind, act, it.val);
      end
    end
  end

  task automatic expect_v(input int kind, input string tag, input int val);
    q.push_back('{kind, tag, val});
    @(negedge clk);
  endtask

  task automatic wr_val(input int v);
    val_we = 1'b1; val_wdata = 16'(v);
    @(negedge clk);
    val_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_mode(input int v);
    mode_we = 1'b1; mode_wdata = 8'(v);
    @(negedge clk);
    mode_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic pin_to(input logic v);
    pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_fall();
    pin_to(1'b0);
    pin_to(1'b1);
  endtask

  task automatic casc_pulse();
    casc = 1'b1;
    @(negedge clk);
    casc = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_v(0, "R1 count", 0);
    expect_v(2, "R1 mode", 0);
    expect_v(1, "R1 uflow", 0);

    wr_mode(8'hFF);
    expect_v(2, "R10 rsvd bits", 8'h1F);
    wr_mode(8'h01);
    expect_v(2, "R10 mode", 8'h01);

    wr_val(3);
    expect_v(0, "R5 stopped write", 3);
    run = 1'b1;
    @(negedge clk);
    wr_val(5);
    expect_v(0, "R5 write before first event", 5);

    // R9: pin change, two edges of sync, counter moves at third edge
    pin = 1'b0;
    repeat (2) @(negedge clk);
    expect_v(0, "R9 not yet", 5);
    expect_v(0, "R9 fall counted", 4);
    repeat (2) @(negedge clk);
    pin_to(1'b1);
    expect_v(0, "R7 rise ignored in fall mode", 4);

    wr_val(2);
    expect_v(0, "R6 write after start keeps count", 4);
    pulse_fall(); expect_v(0, "R2 dec", 3);
    pulse_fall(); expect_v(0, "R2 dec", 2);
    pulse_fall(); expect_v(0, "R11 live", 1);
    pulse_fall(); expect_v(0, "R2 dec", 0);
    expect_v(1, "R3 no uflow yet", 0);
    pulse_fall();
    expect_v(0, "R6 new reload used", 2);
    expect_v(1, "R3 uflow", 1);
    pulse_fall(); pulse_fall(); pulse_fall();
    expect_v(0, "R3 reload after 3 events", 2);
    expect_v(1, "R3 ratio n+1", 2);

    run = 1'b0;
    @(negedge clk);
    pulse_fall(); pulse_fall();
    expect_v(0, "R4 halted", 2);
    wr_val(7);
    expect_v(0, "R5 stopped write", 7);
    run = 1'b1;
    @(negedge clk);

    wr_mode(8'h05);
    pin_to(1'b0); expect_v(0, "R7 fall ignored in rise mode", 7);
    pin_to(1'b1); expect_v(0, "R7 rise counted", 6);
    wr_mode(8'h09);
    pin_to(1'b0); expect_v(0, "R7 both fall", 5);
    pin_to(1'b1); expect_v(0, "R7 both rise", 4);
    wr_mode(8'h0D);
    pin_to(1'b0); pin_to(1'b1);
    expect_v(0, "R7 code 11 no events", 4);

    wr_mode(8'h1D);
    casc_pulse();
    expect_v(0, "R8 cascade counted", 3);
    pin_to(1'b0); pin_to(1'b1);
    expect_v(0, "R8 pin ignored", 3);
    wr_mode(8'h10);
    casc_pulse();
    expect_v(0, "R2 other mode ignored", 3);

    wr_mode(8'h11);
    run = 1'b0;
    @(negedge clk);
    wr_val(0);
    run = 1'b1;
    @(negedge clk);
    casc_pulse();
    expect_v(0, "R3 reload zero", 0);
    expect_v(1, "R3 uflow every event", 3);
    casc_pulse();
    expect_v(1, "R3 uflow every event", 4);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule